// File: doc/BRIEF.md
# OTP Program-and-Verify Pulse Sequencer

This controller writes a range of words into a word-wide one-time-programmable memory. Programming can only clear bits, so it works word by word with a pulse-then-check loop. For each address it fetches the wanted word from a local source port. It reads the current cell contents. If any bit would have to go from 0 back to 1, it stops at once. Otherwise it applies timed chip-enable program pulses, each followed by a read-back, until the word matches or the per-word pulse budget is used up. After the last address it reads the whole range again and compares it against the source.

The sequencer only drives enable strobes for the core and programming supplies. It does not make the supply voltages. All setup, hold, pulse and access intervals are derived from the clock frequency parameter and timed by one shared down-counter. The controller reports busy, done, fail, the failing address and a running total of the program pulses issued in the current run.

Top module: `otp_prog_seq`

## Requirements
- R1: After `start` is accepted in idle, `vpp_en` and `vcc_en` rise together with `busy`. No output-enable strobe (`mem_oe_n` low) occurs until the supplies have been on for at least T_SU = ceil(2 us x CLK_FREQ_HZ) cycles.
- R2: Before pulsing a word, the cell is read once. If the target has a 1 where that read returns 0, the run ends with `fail`=1, `fail_addr` equal to that address, and no pulse on it. Later addresses are never touched.
- R3: Whenever `mem_ce_n` falls, `mem_addr` and `mem_dout` have been stable with `mem_drive`=1 for at least T_SU cycles. During the whole pulse `mem_oe_n`=1, `mem_drive`=1 and the supplies are on.
- R4: Every program pulse holds `mem_ce_n` low for exactly T_PW = ceil(50 us x CLK_FREQ_HZ) cycles.
- R5: After `mem_ce_n` rises, `mem_dout` stays driven and `mem_oe_n` stays high for at least T_SU cycles.
- R6: A read holds `mem_oe_n` low with `mem_drive`=0. `mem_din` is sampled after T_ACC = ceil(120 ns x CLK_FREQ_HZ) cycles of output enable. Drive resumes only after `mem_oe_n` has been high for at least T_FLT = ceil(130 ns x CLK_FREQ_HZ) cycles.
- R7: A word is pulsed again after each failed read-back, up to MAX_PULSES (default 25) pulses:
  - A match on the 25th read-back passes.
  - A mismatch after the 25th pulse ends the run with `fail` and `fail_addr` at that word.
- R8: Addresses are processed in ascending order from `addr_first` to `addr_last`. A word whose blank read already matches its target gets no pulse.
- R9: After the last address, every word in the range is read again in ascending order. Any mismatch ends the run with `fail` and that address; otherwise `done`=1.
- R10: `pulse_total` is cleared when a run starts. It rises by one on each falling edge of `mem_ce_n` and is otherwise unchanged during a run.
- R11: `start` clears `done` and `fail`. Done and fail are never both set. `fail` holds until the next start. While `busy`=0 all strobes are inactive, data is not driven and the supplies are off.
- R12: After reset: `busy`, `done`, `fail`, `vpp_en`, `vcc_en`, `mem_drive` are 0, `mem_ce_n` and `mem_oe_n` are 1, and `pulse_total` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle) |
| addr_first | input | ADDR_W | First address of the range |
| addr_last | input | ADDR_W | Last address of the range (not below first) |
| src_addr | output | ADDR_W | Source port address |
| src_data | input | DATA_W | Target word, valid one cycle after `src_addr` |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data to program |
| mem_drive | output | 1 | Data bus drive enable |
| mem_din | input | DATA_W | Memory read data |
| mem_ce_n | output | 1 | Chip enable, low pulse programs |
| mem_oe_n | output | 1 | Output enable, low reads |
| vpp_en | output | 1 | Programming supply enable |
| vcc_en | output | 1 | Core supply enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with all words matching |
| fail | output | 1 | Run aborted; sticky until next start |
| fail_addr | output | ADDR_W | Address that caused the failure |
| pulse_total | output | TOTAL_W | Pulses issued in this run |

## Verification
All strobes and status flags are registered from the next state. A start seen at one edge therefore shows up as `busy` and the supply enables one clock later. The final `done`/`fail` appears in the same cycle that `busy` drops.

The bench's memory model counts cycles of output enable at each falling clock edge. It returns inverted data until T_ACC such cycles have passed, so a read-back sampled even one cycle early fails the comparison. Pulse width, setup, hold and float gaps are measured at the falling edge between the event edges. Each measured interval is compared with the exact or minimum cycle count from the requirement on the edge where the strobe changes.

// File: rtl/ops_pkg.sv
package ops_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PWR,
    S_FETCH,
    S_LOAD,
    S_READ,
    S_FLOAT,
    S_DSU,
    S_PULSE,
    S_HOLD,
    S_VERIFY,
    S_NEXT
  } seq_state_t;

  // Whole clock cycles covering a duration in nanoseconds, at least one.
  function automatic int unsigned ns_cycles(input longint unsigned hz,
                                            input longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/ops_delay_timer.sv
module ops_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ops_word_judge.sv
module ops_word_judge #(
  parameter int W = 16
) (
  input  logic [W-1:0] target,
  input  logic [W-1:0] readback,
  output logic         match,
  output logic         unreachable
);
  // A cell read as 0 can never return to 1.
  assign match       = (target == readback);
  assign unreachable = |(target & ~readback);
endmodule

// File: rtl/ops_pulse_tally.sv
module ops_pulse_tally #(
  parameter int MAXP    = 25,
  parameter int TOTAL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_run,
  input  logic               clr_word,
  input  logic               bump,
  output logic               limit_hit,
  output logic [TOTAL_W-1:0] total
);
  localparam int CW = $clog2(MAXP + 1);
  logic [CW-1:0] word_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_cnt <= '0;
      total    <= '0;
    end else begin
      if (clr_word)  word_cnt <= '0;
      else if (bump) word_cnt <= word_cnt + 1'b1;
      if (clr_run)   total <= '0;
      else if (bump) total <= total + 1'b1;
    end
  end

  assign limit_hit = (word_cnt == CW'(MAXP));
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import ops_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          DATA_W      = 16,
  parameter int unsigned CLK_FREQ_HZ = 125_000_000,
  parameter int          MAX_PULSES  = 25,
  parameter int          TOTAL_W     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  addr_first,
  input  logic [ADDR_W-1:0]  addr_last,
  output logic [ADDR_W-1:0]  src_addr,
  input  logic [DATA_W-1:0]  src_data,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_dout,
  output logic               mem_drive,
  input  logic [DATA_W-1:0]  mem_din,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  output logic               vpp_en,
  output logic               vcc_en,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [ADDR_W-1:0]  fail_addr,
  output logic [TOTAL_W-1:0] pulse_total
);
  localparam int unsigned T_SU  = ns_cycles(CLK_FREQ_HZ, 2000);
  localparam int unsigned T_PW  = ns_cycles(CLK_FREQ_HZ, 50000);
  localparam int unsigned T_ACC = ns_cycles(CLK_FREQ_HZ, 120);
  localparam int unsigned T_FLT = ns_cycles(CLK_FREQ_HZ, 130);
  localparam int TMR_W = $clog2(T_PW + 1);

  seq_state_t          st, st_nx;
  logic                tmr_load, tmr_exp;
  logic [TMR_W-1:0]    tmr_val;
  logic                match, unreach, limit_hit;
  logic                do_fail, do_done, bump;
  logic                chk_phase;
  logic [ADDR_W-1:0]   cur_addr, first_r, last_r;
  logic [DATA_W-1:0]   target;
  logic                accept;

  assign accept = (st == S_IDLE) && start;

  ops_delay_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  ops_word_judge #(.W(DATA_W)) u_judge (
    .target(target), .readback(mem_din), .match(match), .unreachable(unreach)
  );

  ops_pulse_tally #(.MAXP(MAX_PULSES), .TOTAL_W(TOTAL_W)) u_tally (
    .clk(clk), .rst(rst), .clr_run(accept), .clr_word(st == S_LOAD),
    .bump(bump), .limit_hit(limit_hit), .total(pulse_total)
  );

  always_comb begin
    st_nx    = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    do_fail  = 1'b0;
    do_done  = 1'b0;
    bump     = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        st_nx = S_PWR; tmr_load = 1'b1; tmr_val = TMR_W'(T_SU - 1);
      end
      S_PWR:   if (tmr_exp) st_nx = S_FETCH;
      S_FETCH: st_nx = S_LOAD;
      S_LOAD: begin
        st_nx = S_READ; tmr_load = 1'b1; tmr_val = TMR_W'(T_ACC - 1);
      end
      S_READ: if (tmr_exp) begin
        if (match) st_nx = S_NEXT;
        else if (chk_phase || unreach) begin
          do_fail = 1'b1; st_nx = S_IDLE;
        end else begin
          st_nx = S_FLOAT; tmr_load = 1'b1; tmr_val = TMR_W'(T_FLT - 1);
        end
      end
      S_FLOAT: if (tmr_exp) begin
        st_nx = S_DSU; tmr_load = 1'b1; tmr_val = TMR_W'(T_SU - 1);
      end
      S_DSU: if (tmr_exp) begin
        st_nx = S_PULSE; tmr_load = 1'b1; tmr_val = TMR_W'(T_PW - 1); bump = 1'b1;
      end
      S_PULSE: if (tmr_exp) begin
        st_nx = S_HOLD; tmr_load = 1'b1; tmr_val = TMR_W'(T_SU - 1);
      end
      S_HOLD: if (tmr_exp) begin
        st_nx = S_VERIFY; tmr_load = 1'b1; tmr_val = TMR_W'(T_ACC - 1);
      end
      S_VERIFY: if (tmr_exp) begin
        if (match) st_nx = S_NEXT;
        else if (limit_hit) begin
          do_fail = 1'b1; st_nx = S_IDLE;
        end else begin
          st_nx = S_FLOAT; tmr_load = 1'b1; tmr_val = TMR_W'(T_FLT - 1);
        end
      end
      S_NEXT: begin
        if (chk_phase && cur_addr == last_r) begin
          do_done = 1'b1; st_nx = S_IDLE;
        end else st_nx = S_FETCH;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_drive <= 1'b0;
      vpp_en    <= 1'b0;
      vcc_en    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      chk_phase <= 1'b0;
      cur_addr  <= '0;
      first_r   <= '0;
      last_r    <= '0;
      target    <= '0;
      mem_addr  <= '0;
    end else begin
      st        <= st_nx;
      mem_ce_n  <= (st_nx != S_PULSE);
      mem_oe_n  <= !(st_nx == S_READ || st_nx == S_VERIFY);
      mem_drive <= (st_nx == S_DSU || st_nx == S_PULSE || st_nx == S_HOLD);
      vpp_en    <= (st_nx != S_IDLE);
      vcc_en    <= (st_nx != S_IDLE);
      busy      <= (st_nx != S_IDLE);
      if (accept) begin
        cur_addr  <= addr_first;
        first_r   <= addr_first;
        last_r    <= addr_last;
        chk_phase <= 1'b0;
        done      <= 1'b0;
        fail      <= 1'b0;
      end
      if (st == S_LOAD) begin
        target   <= src_data;
        mem_addr <= cur_addr;
      end
      if (st == S_NEXT) begin
        if (cur_addr == last_r) begin
          if (!chk_phase) begin
            chk_phase <= 1'b1;
            cur_addr  <= first_r;
          end
        end else cur_addr <= cur_addr + 1'b1;
      end
      if (do_fail) begin
        fail      <= 1'b1;
        fail_addr <= cur_addr;
      end
      if (do_done) done <= 1'b1;
    end
  end

  assign src_addr = cur_addr;
  assign mem_dout = target;
endmodule

// File: rtl/ops_prog_seq_chk.sv
module ops_prog_seq_chk #(
  parameter int          ADDR_W      = 20,
  parameter int          DATA_W      = 16,
  parameter int unsigned CLK_FREQ_HZ = 125_000_000,
  parameter int          TOTAL_W     = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               fail,
  input logic               mem_ce_n,
  input logic               mem_oe_n,
  input logic               mem_drive,
  input logic               vpp_en,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [DATA_W-1:0]  mem_dout,
  input logic [TOTAL_W-1:0] pulse_total
);
  localparam int unsigned T_SU  = ops_pkg::ns_cycles(CLK_FREQ_HZ, 2000);
  localparam int unsigned T_PW  = ops_pkg::ns_cycles(CLK_FREQ_HZ, 50000);
  localparam int unsigned T_FLT = ops_pkg::ns_cycles(CLK_FREQ_HZ, 130);

  int unsigned low_cnt, stab_cnt, rise_cnt, oeh_cnt, pwr_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q;

  function automatic int unsigned sat_inc(input int unsigned v);
    return (v < 32'hFFFF_0000) ? v + 1 : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= 0; stab_cnt <= 0; rise_cnt <= 0; oeh_cnt <= 0; pwr_cnt <= 0;
      addr_q <= '0; dout_q <= '0;
    end else begin
      low_cnt  <= mem_ce_n ? 0 : sat_inc(low_cnt);
      stab_cnt <= (mem_drive && mem_addr == addr_q && mem_dout == dout_q) ? sat_inc(stab_cnt) : 0;
      rise_cnt <= mem_ce_n ? sat_inc(rise_cnt) : 0;
      oeh_cnt  <= mem_oe_n ? sat_inc(oeh_cnt) : 0;
      pwr_cnt  <= vpp_en ? sat_inc(pwr_cnt) : 0;
      addr_q   <= mem_addr;
      dout_q   <= mem_dout;
    end
  end

  a_r1_supply_lead: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> pwr_cnt >= T_SU);
  a_r3_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> (stab_cnt >= T_SU) && mem_oe_n);
  a_r3_pulse_ctx: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> mem_oe_n && mem_drive && vpp_en);
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |-> low_cnt == T_PW);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_drive) |-> rise_cnt >= T_SU);
  a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_drive);
  a_r6_float_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_drive) |-> oeh_cnt >= T_FLT);
  a_r10_total_step: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> pulse_total == TOTAL_W'($past(pulse_total) + 1'b1));
  a_r10_total_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && !$fell(mem_ce_n)) |-> $stable(pulse_total));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> mem_ce_n && mem_oe_n && !mem_drive && !vpp_en);
endmodule

bind otp_prog_seq ops_prog_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_FREQ_HZ(CLK_FREQ_HZ), .TOTAL_W(TOTAL_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fail(fail),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_drive(mem_drive),
  .vpp_en(vpp_en), .mem_addr(mem_addr), .mem_dout(mem_dout),
  .pulse_total(pulse_total)
);

// File: tb/otp_prog_seq_bench.sv
module otp_prog_seq_bench;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int TW = 16;
  localparam int unsigned FHZ = 10_000_000;  // scaled timing for a short run
  localparam int T_SU  = 20;   // ceil(2us  * 10MHz)
  localparam int T_PW  = 500;  // ceil(50us * 10MHz)
  localparam int T_ACC = 2;    // ceil(120ns* 10MHz)
  localparam int T_FLT = 2;    // ceil(130ns* 10MHz)
  localparam int NW = 1 << AW;

  logic clk = 0, rst = 1, start = 0;
  logic [AW-1:0] addr_first = '0, addr_last = '0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [DW-1:0] src_data = '0, mem_dout, mem_din;
  logic mem_drive, mem_ce_n, mem_oe_n, vpp_en, vcc_en, busy, done, fail;
  logic [TW-1:0] pulse_total;

  always #4 clk = ~clk;

  otp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_FREQ_HZ(FHZ),
                 .MAX_PULSES(25), .TOTAL_W(TW)) u_otp_prog_seq (
    .clk(clk), .rst(rst), .start(start), .addr_first(addr_first),
    .addr_last(addr_last), .src_addr(src_addr), .src_data(src_data),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_drive(mem_drive),
    .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .vpp_en(vpp_en), .vcc_en(vcc_en), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .pulse_total(pulse_total)
  );

  // Behavioural memory and source
  logic [DW-1:0] arr [NW];
  logic [DW-1:0] tgt [NW];
  logic [DW-1:0] stuck [NW];
  int need [NW];
  int hits [NW];
  int pcount [NW];
  int rd_seq [$];
  bit dist_on = 0;
  int dist_src = 0, dist_dst = 0;
  logic [DW-1:0] dist_mask = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int olc = 0, low_len = 0, su_cnt = 0, since_rise = T_SU, oe_hi = 0, pwr_cnt = 0;
  logic p_ce = 1, p_oe = 1, p_drv = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dout = '0;

  assign mem_din = (olc >= T_ACC) ? arr[mem_addr] : ~arr[mem_addr];

  always @(posedge clk) src_data <= tgt[src_addr];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock port monitor and memory reaction
  always @(negedge clk) begin
    if (rst) begin
      olc = 0; low_len = 0; su_cnt = 0; since_rise = T_SU; oe_hi = 0; pwr_cnt = 0;
      p_ce = 1; p_oe = 1; p_drv = 0;
    end else begin
      if (!busy)
        chk(mem_ce_n && mem_oe_n && !mem_drive && !vpp_en && !vcc_en,
            "R11 idle outputs quiet", {mem_ce_n, mem_oe_n, mem_drive, vpp_en}, 4'b1100);
      if (p_oe && !mem_oe_n) begin
        chk(!mem_drive, "R6 no drive while reading", mem_drive, 0);
        chk(pwr_cnt >= T_SU, "R1 supply lead before strobe", pwr_cnt, T_SU);
        chk(since_rise >= T_SU, "R5 oe gap after pulse", since_rise, T_SU);
        if (rd_seq.size() == 0 || rd_seq[$] != int'(mem_addr)) rd_seq.push_back(int'(mem_addr));
      end
      if (p_ce && !mem_ce_n) begin
        chk(su_cnt >= T_SU, "R3 addr/data setup", su_cnt, T_SU);
        chk(mem_oe_n && vpp_en, "R3 oe high in pulse", {mem_oe_n, vpp_en}, 2'b11);
        pcount[mem_addr]++;
      end
      if (!p_ce && mem_ce_n) begin
        chk(low_len == T_PW, "R4 pulse width", low_len, T_PW);
        if (low_len >= T_PW && mem_oe_n && vpp_en && vcc_en && mem_drive) begin
          hits[mem_addr]++;
          if (hits[mem_addr] >= need[mem_addr])
            arr[mem_addr] = arr[mem_addr] & (mem_dout | stuck[mem_addr]);
          if (dist_on && int'(mem_addr) == dist_src)
            arr[dist_dst] = arr[dist_dst] & ~dist_mask;
        end
      end
      if (p_drv && !mem_drive) chk(since_rise >= T_SU, "R5 data hold", since_rise, T_SU);
      if (!p_drv && mem_drive) chk(oe_hi >= T_FLT, "R6 float gap", oe_hi, T_FLT);
      olc        = mem_oe_n ? 0 : olc + 1;
      low_len    = mem_ce_n ? 0 : low_len + 1;
      su_cnt     = (mem_drive && mem_addr == p_addr && mem_dout == p_dout) ? su_cnt + 1 : 0;
      since_rise = mem_ce_n ? since_rise + 1 : 0;
      oe_hi      = mem_oe_n ? oe_hi + 1 : 0;
      pwr_cnt    = vpp_en ? pwr_cnt + 1 : 0;
      p_ce = mem_ce_n; p_oe = mem_oe_n; p_drv = mem_drive; p_addr = mem_addr; p_dout = mem_dout;
    end
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R11 run never finished actual=%0d expected=0", cyc);
      summary_and_end();
    end
  end

  task automatic run(input int first, input int last);
    rd_seq.delete();
    for (int i = 0; i < NW; i++) begin pcount[i] = 0; hits[i] = 0; end
    @(negedge clk);
    addr_first = AW'(first); addr_last = AW'(last); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && vpp_en && vcc_en, "R1 busy and supplies on after start", {busy, vpp_en}, 2'b11);
    chk(!done && !fail, "R11 start clears flags", {done, fail}, 0);
    chk(pulse_total == 0, "R10 total cleared at start", pulse_total, 0);
    for (int n = 0; n < 150000 && busy; n++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      arr[i] = '1; tgt[i] = '1; stuck[i] = '0; need[i] = 1; hits[i] = 0; pcount[i] = 0;
    end
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !fail && !vpp_en && !vcc_en && !mem_drive,
        "R12 reset flags", {busy, done, fail, vpp_en, mem_drive}, 0);
    chk(mem_ce_n && mem_oe_n && pulse_total == 0, "R12 reset strobes",
        {mem_ce_n, mem_oe_n}, 2'b11);
    rst = 0;
    repeat (2) @(negedge clk);

    // Run A: mixed pulse needs, one already-matching word (R7, R8, R9, R10)
    tgt[2] = 16'hA5F0; need[2] = 1;
    tgt[3] = 16'h1234; need[3] = 3;
    tgt[4] = 16'hFFFF;
    tgt[5] = 16'h0F0F; need[5] = 2;
    run(2, 5);
    chk(done && !fail, "R9 run A done", {done, fail}, 2'b10);
    chk(pulse_total == 6, "R10 run A total", pulse_total, 6);
    chk(pcount[3] == 3, "R7 retries on word 3", pcount[3], 3);
    chk(pcount[4] == 0, "R8 matching word not pulsed", pcount[4], 0);
    chk(arr[2] == 16'hA5F0 && arr[5] == 16'h0F0F, "R7 words programmed", arr[5], 16'h0F0F);
    chk(rd_seq.size() == 8 && rd_seq[0] == 2 && rd_seq[3] == 5 && rd_seq[4] == 2 && rd_seq[7] == 5,
        "R8 R9 ascending program then check order", rd_seq.size(), 8);

    // Run B: impossible 0->1 on word 10 (R2)
    arr[10] = 16'h00FF; tgt[10] = 16'h01FF;
    tgt[9] = 16'hBEEF; tgt[11] = 16'h0000;
    run(9, 11);
    chk(fail && !done && fail_addr == 10, "R2 unreachable target fails", fail_addr, 10);
    chk(pcount[10] == 0 && pulse_total == 1, "R2 no pulse on unreachable word", pcount[10], 0);
    chk(arr[11] == 16'hFFFF, "R2 later word untouched", arr[11], 16'hFFFF);
    chk(rd_seq[$] == 10, "R2 word 11 never read", rd_seq[$], 10);

    // Run C: stuck bit exhausts the pulse budget (R7)
    tgt[20] = 16'h0000; stuck[20] = 16'h0001;
    run(20, 20);
    chk(fail && fail_addr == 20, "R7 budget exhausted fails", fail_addr, 20);
    chk(pcount[20] == 25 && pulse_total == 25, "R7 exactly 25 pulses", pcount[20], 25);
    repeat (50) @(negedge clk);
    chk(fail && !busy, "R11 fail is sticky", fail, 1);

    // Run D: later pulse disturbs earlier word, caught by final check (R9)
    tgt[30] = 16'h00F8; tgt[31] = 16'hC3C3; need[31] = 2; tgt[32] = 16'h7E7E;
    dist_on = 1; dist_src = 32; dist_dst = 30; dist_mask = 16'h0008;
    run(30, 32);
    dist_on = 0;
    chk(fail && !done && fail_addr == 30, "R9 final check catches mismatch", fail_addr, 30);
    chk(pulse_total == 4, "R10 run D total", pulse_total, 4);

    // Run E: word that passes on the 25th pulse (R7 boundary)
    tgt[40] = 16'h8001; need[40] = 25;
    run(40, 40);
    chk(done && !fail, "R7 pass on last allowed pulse", {done, fail}, 2'b10);
    chk(pulse_total == 25 && arr[40] == 16'h8001, "R7 25 pulses then match", pulse_total, 25);

    summary_and_end();
  end
endmodule